// File: doc/BRIEF.md
# Two-Port Semaphore Flag Bank

This block holds a small set of hardware token flags that two independent ports share to agree on who owns a region of shared memory. Each port has its own select, direction, output-enable, address and data lines. A port claims a flag by writing 0 to it and gives it back by writing 1. Only bit 0 of the write data matters. A read returns the flag as seen by that port, copied onto every data bit: all zeros means the reader holds the token, and all ones means it does not.

Claims are atomic. When both ports go for the same free flag in the same clock cycle, the left port (A) wins. The right port's (B) claim is then kept waiting. It is granted automatically when A gives the flag back, unless B withdraws it first by writing 1. The block is fully synchronous to one clock and all read data is registered.

Top module: `sem_flag_unit`

## Requirements
- R1: After synchronous reset every flag is free, and both read-data outputs are 8'hFF.
- R2: A port accesses a flag only when its flag select is low and its chip enable is high. With rd_wr_n low the access is a write. With rd_wr_n high and out_en_n low it is a read. A read with out_en_n high leaves that port's read data unchanged. A write with flag select high changes nothing.
- R3: Chip enable low together with flag select low is an illegal combination and changes no flag state.
- R4: The 3-bit address selects one of eight independent flags. An operation on one flag leaves every other flag untouched.
- R5: A write uses only data bit 0: 0 is a request and 1 is a release. Bits 7..1 are ignored.
- R6: A read loads the port's read data on the following clock edge. The value is all 0 when the reading port owns the addressed flag and all 1 otherwise.
- R7: A request on a free flag makes the requesting port its owner.
- R8: A request on a flag owned by the other port has no effect. A request by the current owner also has no effect.
- R9: When both ports request the same free flag in the same cycle, port A becomes owner and port B's request is left pending.
- R10: When A releases a flag on which B has a pending request, B becomes owner at that same edge.
- R11: A release write by B while its request is pending cancels it, and a later release by A leaves the flag free.
- R12: A release by a port that does not own the flag has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_chip_en_n | input | 1 | Port A chip enable, must be high for a flag access |
| a_flag_sel_n | input | 1 | Port A flag select, active low |
| a_rd_wr_n | input | 1 | Port A direction, 1 = read, 0 = write |
| a_out_en_n | input | 1 | Port A output enable for reads, active low |
| a_addr | input | 3 | Port A flag index |
| a_wdata | input | 8 | Port A write data, bit 0 used |
| a_rdata | output | 8 | Port A registered read data |
| b_chip_en_n | input | 1 | Port B chip enable, must be high for a flag access |
| b_flag_sel_n | input | 1 | Port B flag select, active low |
| b_rd_wr_n | input | 1 | Port B direction, 1 = read, 0 = write |
| b_out_en_n | input | 1 | Port B output enable for reads, active low |
| b_addr | input | 3 | Port B flag index |
| b_wdata | input | 8 | Port B write data, bit 0 used |
| b_rdata | output | 8 | Port B registered read data |

## Verification
The hardest situation to reach is a pending request on B. It exists only after an exact same-cycle tie on a free flag, and the only thing that shows it is B's read-back after A releases the flag. The stimulus table therefore drives both ports in one cycle onto the same flag. It then has A release, or has B cancel and then A release, and reads both ports after each step. This separates "granted to B" from "left free".

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_A    = 2'd1,
    OWN_B    = 2'd2
  } owner_t;
endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
  parameter int DATA_W = 8
) (
  input  logic              chip_en_n,
  input  logic              flag_sel_n,
  input  logic              rd_wr_n,
  input  logic              out_en_n,
  input  logic [DATA_W-1:0] wdata,
  output logic              wr_en,
  output logic              wr_bit,
  output logic              rd_en
);
  logic access;
  logic wdata_unused;

  assign access       = !flag_sel_n && chip_en_n;
  assign wr_en        = access && !rd_wr_n;
  assign rd_en        = access && rd_wr_n && !out_en_n;
  assign wr_bit       = wdata[0];
  assign wdata_unused = ^wdata[DATA_W-1:1];
endmodule

// File: rtl/sem_flag_cell.sv
module sem_flag_cell
  import sem_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic a_wr,
  input  logic a_bit,
  input  logic b_wr,
  input  logic b_bit,
  output logic own_a,
  output logic own_b,
  output logic pend_b
);
  owner_t owner_q;
  logic   pend_b_q;
  logic   req_a, rel_a, req_b, rel_b;

  assign req_a = a_wr && !a_bit;
  assign rel_a = a_wr && a_bit;
  assign req_b = b_wr && !b_bit;
  assign rel_b = b_wr && b_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q  <= OWN_NONE;
      pend_b_q <= 1'b0;
    end else begin
      unique case (owner_q)
        OWN_NONE: begin
          if (req_a) begin
            owner_q  <= OWN_A;
            pend_b_q <= req_b;
          end else if (req_b) begin
            owner_q <= OWN_B;
          end
        end
        OWN_A: begin
          if (rel_a) begin
            owner_q  <= (pend_b_q && !rel_b) ? OWN_B : OWN_NONE;
            pend_b_q <= 1'b0;
          end else if (rel_b) begin
            pend_b_q <= 1'b0;
          end
        end
        OWN_B: begin
          if (rel_b) owner_q <= OWN_NONE;
        end
        default: owner_q <= OWN_NONE;
      endcase
    end
  end

  assign own_a  = (owner_q == OWN_A);
  assign own_b  = (owner_q == OWN_B);
  assign pend_b = pend_b_q;
endmodule

// File: rtl/sem_read_path.sv
module sem_read_path #(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 8,
  localparam int ADDR_W   = $clog2(NUM_FLAGS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_FLAGS-1:0] own_self,
  output logic [DATA_W-1:0]    rdata
);
  always_ff @(posedge clk) begin
    if (rst)        rdata <= '1;
    else if (rd_en) rdata <= {DATA_W{!own_self[addr]}};
  end
endmodule

// File: rtl/sem_flag_unit.sv
module sem_flag_unit #(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 8,
  localparam int ADDR_W   = $clog2(NUM_FLAGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_chip_en_n,
  input  logic              a_flag_sel_n,
  input  logic              a_rd_wr_n,
  input  logic              a_out_en_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_chip_en_n,
  input  logic              b_flag_sel_n,
  input  logic              b_rd_wr_n,
  input  logic              b_out_en_n,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);
  logic a_wr_en, a_wr_bit, a_rd_en;
  logic b_wr_en, b_wr_bit, b_rd_en;
  logic [NUM_FLAGS-1:0] own_a_vec, own_b_vec, pend_b_vec;

  sem_port_decode #(.DATA_W(DATA_W)) u_dec_a (
    .chip_en_n(a_chip_en_n), .flag_sel_n(a_flag_sel_n), .rd_wr_n(a_rd_wr_n),
    .out_en_n(a_out_en_n), .wdata(a_wdata),
    .wr_en(a_wr_en), .wr_bit(a_wr_bit), .rd_en(a_rd_en)
  );

  sem_port_decode #(.DATA_W(DATA_W)) u_dec_b (
    .chip_en_n(b_chip_en_n), .flag_sel_n(b_flag_sel_n), .rd_wr_n(b_rd_wr_n),
    .out_en_n(b_out_en_n), .wdata(b_wdata),
    .wr_en(b_wr_en), .wr_bit(b_wr_bit), .rd_en(b_rd_en)
  );

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    sem_flag_cell u_cell (
      .clk(clk), .rst(rst),
      .a_wr(a_wr_en && (a_addr == ADDR_W'(i))), .a_bit(a_wr_bit),
      .b_wr(b_wr_en && (b_addr == ADDR_W'(i))), .b_bit(b_wr_bit),
      .own_a(own_a_vec[i]), .own_b(own_b_vec[i]), .pend_b(pend_b_vec[i])
    );
  end

  sem_read_path #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_rd_a (
    .clk(clk), .rst(rst), .rd_en(a_rd_en), .addr(a_addr),
    .own_self(own_a_vec), .rdata(a_rdata)
  );

  sem_read_path #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_rd_b (
    .clk(clk), .rst(rst), .rd_en(b_rd_en), .addr(b_addr),
    .own_self(own_b_vec), .rdata(b_rdata)
  );
endmodule

// File: rtl/sem_flag_unit_chk.sv
module sem_flag_unit_chk #(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 8,
  localparam int ADDR_W   = $clog2(NUM_FLAGS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 a_chip_en_n,
  input logic                 a_flag_sel_n,
  input logic                 a_rd_wr_n,
  input logic [ADDR_W-1:0]    a_addr,
  input logic [DATA_W-1:0]    a_wdata,
  input logic [DATA_W-1:0]    a_rdata,
  input logic                 b_chip_en_n,
  input logic                 b_flag_sel_n,
  input logic                 b_rd_wr_n,
  input logic [ADDR_W-1:0]    b_addr,
  input logic [DATA_W-1:0]    b_wdata,
  input logic [DATA_W-1:0]    b_rdata,
  input logic [NUM_FLAGS-1:0] own_a_vec,
  input logic [NUM_FLAGS-1:0] own_b_vec,
  input logic [NUM_FLAGS-1:0] pend_b_vec
);
  // R6: read data is always a whole-byte copy of one flag bit
  a_r6_replicated: assert property (@(posedge clk) disable iff (rst)
    (a_rdata == '0 || a_rdata == '1) && (b_rdata == '0 || b_rdata == '1));

  // R3: illegal select combination on A with B idle leaves the flags alone
  a_r3_illegal_no_change: assert property (@(posedge clk) disable iff (rst)
    (!a_chip_en_n && !a_flag_sel_n && b_flag_sel_n)
    |=> ($stable(own_a_vec) && $stable(own_b_vec)));

  // R9: a pending B request exists only under an A owner
  a_r9_pend_needs_owner: assert property (@(posedge clk) disable iff (rst)
    (pend_b_vec & ~own_a_vec) == '0);

  // R9: same-cycle requests on a free flag go to A
  a_r9_tie_to_a: assert property (@(posedge clk) disable iff (rst)
    (a_chip_en_n && !a_flag_sel_n && !a_rd_wr_n && !a_wdata[0] &&
     b_chip_en_n && !b_flag_sel_n && !b_rd_wr_n && !b_wdata[0] &&
     a_addr == b_addr && !own_a_vec[a_addr] && !own_b_vec[a_addr])
    |=> own_a_vec[$past(a_addr)]);

  // R8: both ports never see ownership of one flag at once
  a_r8_single_owner: assert property (@(posedge clk) disable iff (rst)
    (own_a_vec & own_b_vec) == '0);

  // R12: B releasing an A-owned flag does not free it
  a_r12_foreign_release: assert property (@(posedge clk) disable iff (rst)
    (b_chip_en_n && !b_flag_sel_n && !b_rd_wr_n && b_wdata[0] &&
     own_a_vec[b_addr] && (a_flag_sel_n || a_rd_wr_n))
    |=> own_a_vec[$past(b_addr)]);
endmodule

bind sem_flag_unit sem_flag_unit_chk #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst),
  .a_chip_en_n(a_chip_en_n), .a_flag_sel_n(a_flag_sel_n), .a_rd_wr_n(a_rd_wr_n),
  .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
  .b_chip_en_n(b_chip_en_n), .b_flag_sel_n(b_flag_sel_n), .b_rd_wr_n(b_rd_wr_n),
  .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
  .own_a_vec(own_a_vec), .own_b_vec(own_b_vec), .pend_b_vec(pend_b_vec)
);

// File: tb/sim_sem_flag_unit.sv
module sim_sem_flag_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_ce_n, a_sel_n, a_rw, a_oe_n, b_ce_n, b_sel_n, b_rw, b_oe_n;
  logic [2:0] a_ad, b_ad;
  logic [7:0] a_wd, b_wd, a_rd, b_rd;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sem_flag_unit u0 (
    .clk(clk), .rst(rst),
    .a_chip_en_n(a_ce_n), .a_flag_sel_n(a_sel_n), .a_rd_wr_n(a_rw), .a_out_en_n(a_oe_n),
    .a_addr(a_ad), .a_wdata(a_wd), .a_rdata(a_rd),
    .b_chip_en_n(b_ce_n), .b_flag_sel_n(b_sel_n), .b_rd_wr_n(b_rw), .b_out_en_n(b_oe_n),
    .b_addr(b_ad), .b_wdata(b_wd), .b_rdata(b_rd)
  );

  // op codes: 0 idle, 1 request (bit0=0, upper bits set), 2 release (bit0=1), 3 read
  localparam logic [1:0] IDL = 2'd0, REQ = 2'd1, REL = 2'd2, RD = 2'd3;

  // {a_op, a_addr, b_op, b_addr, check_addr, exp_a_bit, exp_b_bit}
  localparam int NV = 15;
  localparam logic [14:0] VEC [NV] = '{
    {REQ, 3'd2, IDL, 3'd0, 3'd2, 1'b0, 1'b1},  // R7
    {IDL, 3'd0, REQ, 3'd2, 3'd2, 1'b0, 1'b1},  // R8
    {IDL, 3'd0, REL, 3'd2, 3'd2, 1'b0, 1'b1},  // R12
    {REL, 3'd2, IDL, 3'd0, 3'd2, 1'b1, 1'b1},  // R7 release
    {REQ, 3'd5, REQ, 3'd5, 3'd5, 1'b0, 1'b1},  // R9
    {REL, 3'd5, IDL, 3'd0, 3'd5, 1'b1, 1'b0},  // R10
    {IDL, 3'd0, REL, 3'd5, 3'd5, 1'b1, 1'b1},  // R10 B release
    {REQ, 3'd6, REQ, 3'd6, 3'd6, 1'b0, 1'b1},  // R9
    {IDL, 3'd0, REL, 3'd6, 3'd6, 1'b0, 1'b1},  // R11
    {REL, 3'd6, IDL, 3'd0, 3'd6, 1'b1, 1'b1},  // R11
    {IDL, 3'd0, REQ, 3'd0, 3'd0, 1'b1, 1'b0},  // R7 B
    {REQ, 3'd1, IDL, 3'd0, 3'd1, 1'b0, 1'b1},  // R4
    {IDL, 3'd0, IDL, 3'd0, 3'd0, 1'b1, 1'b0},  // R4
    {REQ, 3'd0, IDL, 3'd0, 3'd0, 1'b1, 1'b0},  // R8
    {REL, 3'd0, IDL, 3'd0, 3'd0, 1'b1, 1'b0}   // R12
  };

  task automatic drv_a(input logic [1:0] op, input logic [2:0] ad);
    a_ce_n = 1'b1; a_sel_n = (op == IDL); a_ad = ad;
    a_rw = (op == RD) || (op == IDL); a_oe_n = (op != RD);
    a_wd = (op == REQ) ? 8'hFE : 8'h01;
  endtask

  task automatic drv_b(input logic [1:0] op, input logic [2:0] ad);
    b_ce_n = 1'b1; b_sel_n = (op == IDL); b_ad = ad;
    b_rw = (op == RD) || (op == IDL); b_oe_n = (op != RD);
    b_wd = (op == REQ) ? 8'hFE : 8'h01;
  endtask

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // read both ports at one address; compare after the loading edge
  task automatic read_both(input logic [2:0] ad, input logic ea, input logic eb, input string req);
    drv_a(RD, ad); drv_b(RD, ad);
    @(negedge clk);
    drv_a(IDL, 3'd0); drv_b(IDL, 3'd0);
    check(req, a_rd, {8{ea}});
    check(req, b_rd, {8{eb}});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    drv_a(IDL, 3'd0); drv_b(IDL, 3'd0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset a", a_rd, 8'hFF);
    check("R1 reset b", b_rd, 8'hFF);
    read_both(3'd3, 1'b1, 1'b1, "R1 free");

    for (int i = 0; i < NV; i++) begin
      drv_a(VEC[i][14:13], VEC[i][12:10]);
      drv_b(VEC[i][9:8], VEC[i][7:5]);
      @(negedge clk);
      read_both(VEC[i][4:2], VEC[i][1], VEC[i][0], $sformatf("R5/R6 vector %0d", i));
    end

    // R3: illegal select combination requesting flag 3
    drv_a(REQ, 3'd3); a_ce_n = 1'b0;
    @(negedge clk);
    read_both(3'd3, 1'b1, 1'b1, "R3 illegal");

    // R2: write with flag select high has no effect
    drv_a(REQ, 3'd4); a_sel_n = 1'b1;
    @(negedge clk);
    read_both(3'd4, 1'b1, 1'b1, "R2 deselected");

    // R2: A owns flag 1; read it, then a read with out_en_n high must hold 00
    read_both(3'd1, 1'b0, 1'b1, "R2 owned read");
    drv_a(RD, 3'd7); a_oe_n = 1'b1;
    @(negedge clk);
    drv_a(IDL, 3'd0);
    check("R2 oe high hold", a_rd, 8'h00);

    // R5: upper data bits set with bit0=1 still releases
    a_ce_n = 1'b1; a_sel_n = 1'b0; a_rw = 1'b0; a_ad = 3'd1; a_wd = 8'hFF;
    @(negedge clk);
    drv_a(IDL, 3'd0);
    read_both(3'd1, 1'b1, 1'b1, "R5 bit0 release");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule